// File: doc/BRIEF.md
# Synchronous Up/Down Binary Counter

This block is an n-bit binary counter whose flip-flops all sample on the rising edge of one shared clock. Internally the stored value only ever advances upward. A serial chain of AND terms tells each bit when every bit below it is set, and that bit then inverts on the next counting edge. Bit 0 has no lower bits and so inverts on every counting edge.

Downward counting does not use a second decrement path. A per-bit output multiplexer presents either the stored value or its bitwise inverse, chosen by a direction select. Because the inverse of an incrementing sequence is a decrementing one, the 4-bit output in down mode runs 1111, 1110, 1101 and on to 0000 from reset.

A carry-out flags the edge on which the stored value wraps. Wider counters are built by feeding that flag into the enable of the next stage. Changing direction affects only the output, and it does so in the same cycle.

Top module: `udc_counter`

## Requirements
- R1: A rising clock edge with `rst_i` = 1 clears the stored value to zero. After that edge `count_o` reads 0 in up mode and all ones in down mode.
- R2: A rising edge with `rst_i` = 0 and `cnt_en_i` = 1 advances the stored value by one, modulo 2^WIDTH. Bit 0 inverts on every such edge, and bit i inverts only when all bits below i are 1.
- R3: While `cnt_en_i` = 0 the stored value holds across clock edges and `carry_o` is 0.
- R4: With `dir_down_i` = 0, `count_o` equals the stored value. With `dir_down_i` = 1, `count_o` equals its bitwise inverse. A change of `dir_down_i` shows at `count_o` in the same cycle and leaves the stored value unchanged.
- R5: `carry_o` is 1 exactly when `cnt_en_i` = 1 and every stored bit is 1, combinationally in that cycle. On that edge the stored value wraps to zero.
- R6: Reset takes priority over the count enable: `rst_i` = 1 with `cnt_en_i` = 1 still yields zero.
- R7: Two instances chained, with the low `carry_o` driving the high `cnt_en_i` and a shared `dir_down_i`, behave as one counter of 2*WIDTH bits in both directions. WIDTH defaults to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Count enable; 1 advances on the next edge |
| dir_down_i | input | 1 | Direction select: 0 up, 1 down (inverted output) |
| count_o | output | WIDTH | Count value after the direction multiplexer |
| carry_o | output | 1 | Wrap flag for cascading stages |

## Verification
The assertions check on every cycle that reset leaves zero, that an enabled edge adds exactly one, that a disabled edge holds the value with carry low, and that a carry edge is followed by zero. Only the bench scenarios can show the output side. That covers the inverted down sequence, direction changes in the middle of a run that do not disturb the count, and reset winning over enable. It also covers the two-stage cascade acting as one 8-bit counter across its full wrap.

// File: rtl/udc_pkg.sv
package udc_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } udc_dir_e;

endpackage

// File: rtl/udc_and_chain.sv
module udc_and_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] toggle_o,
    output logic             all_ones_o
);

    logic [WIDTH:0] chain;

    assign chain[0] = 1'b1;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            assign chain[i+1]  = chain[i] & state_i[i];
            assign toggle_o[i] = chain[i];
        end
    endgenerate

    assign all_ones_o = chain[WIDTH];

endmodule

// File: rtl/udc_state_reg.sv
module udc_state_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [WIDTH-1:0] toggle_i,
    output logic [WIDTH-1:0] state_o
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.cnt = '0;
        end else if (en_i) begin
            st_d.cnt = st_q.cnt ^ toggle_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign state_o = st_q.cnt;

    AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (st_q.cnt == '0)); // R1

    AST_INCREMENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !$isunknown(st_q.cnt)) |=> (rst_i || st_q.cnt == $past(st_q.cnt) + ONE)); // R2

    AST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !$isunknown(st_q.cnt)) |=> (rst_i || $stable(st_q.cnt))); // R3

endmodule

// File: rtl/udc_dir_mux.sv
module udc_dir_mux
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] state_i,
    input  logic             dir_i,
    output logic [WIDTH-1:0] count_o
);

    udc_dir_e dir;
    assign dir = udc_dir_e'(dir_i);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign count_o[i] = (dir == DIR_DOWN) ? ~state_i[i] : state_i[i];
        end
    endgenerate

endmodule

// File: rtl/udc_counter.sv
module udc_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cnt_en_i,
    input  logic             dir_down_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_o
);

    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] toggle;
    logic             all_ones;

    udc_and_chain #(.WIDTH(WIDTH)) u_chain (
        .state_i    (state),
        .toggle_o   (toggle),
        .all_ones_o (all_ones)
    );

    udc_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (cnt_en_i),
        .toggle_i (toggle),
        .state_o  (state)
    );

    udc_dir_mux #(.WIDTH(WIDTH)) u_mux (
        .state_i (state),
        .dir_i   (dir_down_i),
        .count_o (count_o)
    );

    assign carry_o = cnt_en_i & all_ones;

    AST_CARRY_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        carry_o |=> (rst_i || state == '0)); // R5

    AST_CARRY_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !cnt_en_i |-> !carry_o); // R3

endmodule

// File: tb/udc_counter_tb.sv
`timescale 1ns/1ps
module udc_counter_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b0;
    logic         en  = 1'b0;
    logic         dir = 1'b0;
    logic [W-1:0] lo_cnt, hi_cnt;
    logic         lo_carry, hi_carry;

    int checks = 0;
    int fails  = 0;
    int model  = 0;   // 2*W-bit reference value
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    udc_counter #(.WIDTH(W)) u_dut (
        .clk_i(clk), .rst_i(rst), .cnt_en_i(en), .dir_down_i(dir),
        .count_o(lo_cnt), .carry_o(lo_carry)
    );

    udc_counter #(.WIDTH(W)) u_hi (
        .clk_i(clk), .rst_i(rst), .cnt_en_i(lo_carry), .dir_down_i(dir),
        .count_o(hi_cnt), .carry_o(hi_carry)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive inputs at the falling edge, check outputs, then update the model at the rising edge.
    task automatic step(input bit r, input bit e, input bit d, input string req);
        int lo_m, exp_lo, exp_full, full;
        @(negedge clk);
        rst = r; en = e; dir = d;
        #1;
        lo_m     = model % 16;
        exp_lo   = d ? (~lo_m & 15) : lo_m;
        exp_full = d ? (~model & 255) : model;
        full     = {24'd0, hi_cnt, lo_cnt};
        check({req, " count_o"}, int'(lo_cnt), exp_lo);
        check({req, " carry_o"}, int'(lo_carry), (e && lo_m == 15) ? 1 : 0);
        check("R7 cascade value", full, exp_full);
        check("R7 cascade carry", int'(hi_carry), (e && model == 255) ? 1 : 0);
        @(posedge clk);
        if (r) model = 0;
        else if (e) model = (model + 1) % 256;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state in both directions
        step(1, 0, 0, "R1 reset");
        step(1, 0, 0, "R1 reset");
        step(0, 0, 0, "R1 up after reset");
        step(0, 0, 1, "R1 down after reset");
        // R2: count up across a low-stage wrap (R5)
        for (int i = 0; i < 20; i++) step(0, 1, 0, "R2 up count");
        // R3: hold with enable low, carry low
        for (int i = 0; i < 5; i++) step(0, 0, 0, "R3 hold");
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R3 hold down");
        // R4: direction changes mid-run
        for (int i = 0; i < 12; i++) step(0, 1, i[0], "R4 dir toggle");
        // R6: reset wins over enable
        step(1, 1, 0, "R6 reset priority");
        step(0, 0, 0, "R6 after reset");
        // R4: down sequence from zero: 1111, 1110, 1101 ...
        for (int i = 0; i < 18; i++) step(0, 1, 1, "R4 down count");
        // R5 / R7: run across the full 8-bit wrap
        for (int i = 0; i < 300; i++) step(0, 1, (i / 37) % 2 == 1, "R5 wrap");
        // R3: enable low exactly at all-ones
        step(1, 0, 0, "R1 reset");
        for (int i = 0; i < 15; i++) step(0, 1, 0, "R2 to max");
        step(0, 0, 0, "R3 max hold");
        step(0, 1, 0, "R5 carry at max");
        step(0, 0, 0, "R5 after wrap");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule